// File: doc/BRIEF.md
# Piecewise-Ratio Clock Divider

This block turns a fast reference clock, nominally 96 MHz, into a slower square wave. Software chooses the output rate by writing a 6-bit ratio selector into a 16-bit control word. The selector does not map to the divisor in a straight line. The low selector codes step the divisor by one, up to a divide of 8. Every code above that adds two to the divisor, so odd divisors above 8 cannot be reached. Codes that would give a divisor past 96 are held at 96.

A source-select bit in the control word lets the divider count on a bypass tick instead of on every reference cycle. A second write strobe rewrites only the ratio field. It leaves the bits software does not own untouched and forces the divider back onto the reference.

A new ratio is held back until the current output period ends, so the output never shows a shortened pulse. The divisor in use is driven on a status output, and software computes the frequency from it.

Top module: `ratio_clkdiv`

## Requirements
- R1: After reset the control word reads 0x0000, the divisor in use is 2, the divider counts the reference, and the output is high.
- R2: The selector is control bits [7:2]. For selector values 0 to 6 the divisor is the selector plus 2, which covers divisors 2 to 8.
- R3: For selector values above 6 the divisor is 8 + 2 × (selector − 6), and it is always even.
- R4: A selector that would give a divisor above 96 (codes 51 to 63) gives a divisor of exactly 96. Code 50 gives 96 through the normal formula. The divisor in use always stays between 2 and 96.
- R5: A pulse on `reg_wr_en` loads all 16 bits of `reg_wdata`, and the new value reads back on `reg_rdata` from the next cycle on. When `reg_wr_en` and `ratio_wr_en` are pulsed together, the full write wins.
- R6: A pulse on `ratio_wr_en` alone does three things:
  - it loads bits [7:2] from `reg_wdata`;
  - it clears bit 0;
  - it keeps bit 1 and bits [15:8] as they were.
- R7: A changed divisor takes effect only at the end of the current output period. The period in progress finishes with its old length, and `div_now` keeps its old value until then.
- R8: Each period lasts `div_now` counting steps. The output is high for the first floor(div/2) steps and low for the rest. `period_strobe` is high only during the last step of a period.
- R9: Control bit 0 selects the counting source:
  - 0: the divider counts one step on every reference clock cycle;
  - 1: it counts only on cycles where `alt_tick` is high.
  
  While bit 0 is 1 and `alt_tick` stays low, the output holds still.
- R10: `div_now` reports the divisor of the period currently running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_tick | input | 1 | Bypass count enable, used when control bit 0 is 1 |
| reg_wr_en | input | 1 | Full control word write strobe |
| ratio_wr_en | input | 1 | Ratio-only write strobe (bits [7:2], clears bit 0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Control word readback |
| div_now | output | 7 | Divisor of the running period |
| clk_out | output | 1 | Divided square wave |
| period_strobe | output | 1 | High during the last counting step of each period |

## Verification
The assertions check four things on every cycle:
- the step counter stays below the running divisor;
- the divisor stays within 2 to 96, and is even above the knee;
- the divisor only changes at a period boundary, and the counter is frozen when no step is granted;
- a ratio-only write keeps the bits it does not own.

Only the bench scenarios can show the measured period and high time for particular selector codes. The same holds for the clamp at 96, the exact length of a period that is interrupted by a rewrite, and the timing under a sparse bypass tick.

// File: rtl/ratio_clkdiv_pkg.sv
package ratio_clkdiv_pkg;

  localparam int CTRL_W = 16;
  localparam int SEL_W  = 6;

  // Counting source carried in control bit 0
  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_ALT = 1'b1
  } src_e;

  // Control word layout; the selector position is decoded by the ratio map
  typedef struct packed {
    logic [7:0]       upper;
    logic [SEL_W-1:0] sel;
    logic             keep;
    src_e             src;
  } ctrl_s;

endpackage

// File: rtl/ratio_clkdiv_regs.sv
module ratio_clkdiv_regs
  import ratio_clkdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  full_we,
  input  logic  ratio_we,
  input  ctrl_s wdata,
  output ctrl_s ctrl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (full_we) begin
      ctrl_q <= wdata;
    end else if (ratio_we) begin
      ctrl_q.sel <= wdata.sel;
      ctrl_q.src <= SRC_REF;
    end
  end

  AST_RATIO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_we && !full_we) |=> (ctrl_q.upper == $past(ctrl_q.upper)
      && ctrl_q.keep == $past(ctrl_q.keep) && ctrl_q.src == SRC_REF)); // R6

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    full_we |=> (ctrl_q == $past(wdata))); // R5

endmodule

// File: rtl/ratio_clkdiv_map.sv
module ratio_clkdiv_map #(
  parameter int SEL_W    = 6,
  parameter int DIV_MIN  = 2,
  parameter int LIN_LAST = 6,
  parameter int STEP_HI  = 2,
  parameter int DIV_MAX  = 96,
  parameter int DIV_W    = $clog2(DIV_MAX + 1)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [DIV_W-1:0] div
);

  localparam int KNEE = DIV_MIN + LIN_LAST;

  int raw;

  always_comb begin
    if (int'(sel) <= LIN_LAST) begin
      raw = DIV_MIN + int'(sel);
    end else begin
      raw = KNEE + STEP_HI * (int'(sel) - LIN_LAST);
    end
    if (raw > DIV_MAX) begin
      raw = DIV_MAX;
    end
    div = DIV_W'(raw);
  end

endmodule

// File: rtl/ratio_clkdiv_core.sv
module ratio_clkdiv_core #(
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 96,
  parameter int DIV_W   = $clog2(DIV_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [DIV_W-1:0] div_next,
  output logic [DIV_W-1:0] div_cur,
  output logic             wave,
  output logic             period_end
);

  logic [DIV_W-1:0] cnt;
  logic             last;

  assign last       = (cnt == div_cur - 1'b1);
  assign period_end = adv && last;
  assign wave       = (cnt < (div_cur >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_cur <= DIV_W'(DIV_MIN);
    end else if (adv) begin
      if (last) begin
        cnt     <= '0;
        div_cur <= div_next;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < div_cur); // R8

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cur >= DIV_W'(DIV_MIN)) && (div_cur <= DIV_W'(DIV_MAX))); // R4

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(div_cur)); // R7

  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt)); // R9

endmodule

// File: rtl/ratio_clkdiv.sv
module ratio_clkdiv
  import ratio_clkdiv_pkg::*;
#(
  parameter int DIV_MIN  = 2,
  parameter int LIN_LAST = 6,
  parameter int DIV_MAX  = 96,
  parameter int DIV_W    = $clog2(DIV_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_tick,
  input  logic              reg_wr_en,
  input  logic              ratio_wr_en,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic [DIV_W-1:0]  div_now,
  output logic              clk_out,
  output logic              period_strobe
);

  ctrl_s            wr_s;
  ctrl_s            ctrl_q;
  logic [DIV_W-1:0] div_pend;
  logic             adv;

  assign wr_s      = ctrl_s'(reg_wdata);
  assign reg_rdata = CTRL_W'(ctrl_q);
  assign adv       = (ctrl_q.src == SRC_ALT) ? alt_tick : 1'b1;

  ratio_clkdiv_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .full_we  (reg_wr_en),
    .ratio_we (ratio_wr_en),
    .wdata    (wr_s),
    .ctrl_q   (ctrl_q)
  );

  ratio_clkdiv_map #(
    .SEL_W    (SEL_W),
    .DIV_MIN  (DIV_MIN),
    .LIN_LAST (LIN_LAST),
    .STEP_HI  (2),
    .DIV_MAX  (DIV_MAX),
    .DIV_W    (DIV_W)
  ) u_map (
    .sel (ctrl_q.sel),
    .div (div_pend)
  );

  ratio_clkdiv_core #(
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX),
    .DIV_W   (DIV_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .div_next   (div_pend),
    .div_cur    (div_now),
    .wave       (clk_out),
    .period_end (period_strobe)
  );

  AST_EVEN_ABOVE_KNEE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ctrl_q.sel) > LIN_LAST) |-> (div_pend[0] == 1'b0)); // R3

  AST_LINEAR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ctrl_q.sel) <= LIN_LAST) |-> (int'(div_pend) == DIV_MIN + int'(ctrl_q.sel))); // R2

endmodule

// File: tb/ratio_clkdiv_tb.sv
`timescale 1ns/1ps
module ratio_clkdiv_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alt_tick;
  logic        reg_wr_en;
  logic        ratio_wr_en;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [6:0]  div_now;
  logic        clk_out;
  logic        period_strobe;
  logic        alt_mode;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  ratio_clkdiv u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .alt_tick      (alt_tick),
    .reg_wr_en     (reg_wr_en),
    .ratio_wr_en   (ratio_wr_en),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .div_now       (div_now),
    .clk_out       (clk_out),
    .period_strobe (period_strobe)
  );

  // bypass tick: one cycle in three, changed just after the rising edge
  initial begin
    int ph;
    ph = 0;
    alt_tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (alt_mode) begin
        ph = (ph + 1) % 3;
        alt_tick = (ph == 0);
      end else begin
        alt_tick = 1'b0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic full_wr(logic [15:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic ratio_wr(logic [15:0] v);
    @(negedge clk);
    ratio_wr_en = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    ratio_wr_en = 1'b0;
  endtask

  task automatic align(string tag);
    int g;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!period_strobe && g < 400);
    if (g >= 400) chk({tag, " strobe seen"}, 0, 1);
  endtask

  // counts steps from the current negedge up to and including the strobe
  task automatic measure(output int n, output int h);
    n = 0;
    h = 0;
    while (1) begin
      n++;
      h += int'(clk_out);
      if (period_strobe || n >= 400) break;
      @(negedge clk);
    end
  endtask

  task automatic period_check(string tag, int d);
    int n, h;
    align(tag);
    @(negedge clk);
    chk({tag, " div_now (R10)"}, int'(div_now), d);
    measure(n, h);
    chk({tag, " period"}, n, d);
    chk({tag, " high time (R8)"}, h, d / 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 ctrl", int'(reg_rdata), 0);
    chk("R1 div", int'(div_now), 2);
    chk("R1 out", int'(clk_out), 1);
    rst_n = 1'b1;
    period_check("R1 run", 2);
  endtask

  task automatic t_linear();
    full_wr(16'h0004);
    period_check("R2 sel1", 3);
    full_wr(16'h0018);
    period_check("R2 sel6", 8);
  endtask

  task automatic t_even();
    full_wr(16'h001C);
    period_check("R3 sel7", 10);
    full_wr(16'h00C4);
    period_check("R3 sel49", 94);
  endtask

  task automatic t_clamp();
    full_wr(16'h00C8);
    period_check("R4 sel50", 96);
    full_wr(16'h00FC);
    period_check("R4 sel63", 96);
  endtask

  task automatic t_writes();
    @(negedge clk);
    reg_wr_en   = 1'b1;
    ratio_wr_en = 1'b1;
    reg_wdata   = 16'h1234;
    @(negedge clk);
    reg_wr_en   = 1'b0;
    ratio_wr_en = 1'b0;
    chk("R5 full wins", int'(reg_rdata), 16'h1234);
    full_wr(16'hA507);
    chk("R5 full load", int'(reg_rdata), 16'hA507);
    ratio_wr(16'h5528);
    chk("R6 ratio only", int'(reg_rdata), 16'hA52A);
    period_check("R6 sel10", 16);
  endtask

  task automatic t_midperiod();
    int n, h;
    full_wr(16'h0030);
    align("R7");
    @(negedge clk);
    @(negedge clk);
    ratio_wr_en = 1'b1;
    reg_wdata   = 16'h0004;
    @(negedge clk);
    ratio_wr_en = 1'b0;
    chk("R7 div held", int'(div_now), 20);
    measure(n, h);
    chk("R7 remaining steps", n, 18);
    chk("R7 remaining high", h, 8);
    @(negedge clk);
    chk("R7 new div", int'(div_now), 3);
    measure(n, h);
    chk("R7 new period", n, 3);
    chk("R7 new high", h, 1);
  endtask

  task automatic t_alt();
    int n, h, strobes, changes;
    logic prev;
    alt_mode = 1'b1;
    full_wr(16'h0001);
    align("R9 alt");
    @(negedge clk);
    measure(n, h);
    chk("R9 alt period", n, 6);
    chk("R9 alt high", h, 3);
    alt_mode = 1'b0;
    repeat (3) @(negedge clk);
    prev = clk_out;
    strobes = 0;
    changes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (period_strobe) strobes++;
      if (clk_out != prev) changes++;
      prev = clk_out;
    end
    chk("R9 stall strobes", strobes, 0);
    chk("R9 stall changes", changes, 0);
    full_wr(16'h0000);
    period_check("R9 ref again", 2);
  endtask

  initial begin
    rst_n       = 1'b0;
    reg_wr_en   = 1'b0;
    ratio_wr_en = 1'b0;
    reg_wdata   = '0;
    alt_mode    = 1'b0;
    t_reset();
    t_linear();
    t_even();
    t_clamp();
    t_writes();
    t_midperiod();
    t_alt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule